// File: doc/BRIEF.md
# Receive Sample Router and Word Interleaver

This block sits between four receive converters and the host bus. Each of up to four receive channels has an in-phase input and a quadrature input. Each of these inputs can take its samples from any one of the four converters, and one converter can feed several channels at once. The 12-bit converter samples are widened with their sign to 16 bits. Once per output sample period, a decimating stub that stands in for the downconverter arithmetic captures the routed samples of all channels together. A serializer then sends the captured group to the host as a stream of signed 16-bit words under a valid/ready handshake.

Software writes the routing, the channel count and the decimation setting through a single write strobe. These settings are staged, and they reach the datapath only when a group is captured, so no group ever mixes old and new settings. If the host side is too slow and the previous group is still being sent when a new group is captured, the new group is discarded as a whole and a sticky overrun flag is raised.

Top module: `rx_route_ilv`

## Requirements
- R1: Every output word is the selected 12-bit converter sample with its bit 11 copied into bits 15..12.
- R2: For channel c, the in-phase input takes converter `cfg_route[4c+1:4c]` and the quadrature input takes converter `cfg_route[4c+3:4c+2]`, where converter k is `adc_bus[12k+11:12k]`. Any converter may feed any number of channel inputs.
- R3: A group goes out as channel 0 in-phase, channel 0 quadrature, channel 1 in-phase, channel 1 quadrature, and so on in ascending channel order. The next group starts again at channel 0 in-phase.
- R4: `cfg_nchan` selects the active channels: 00 selects one channel (2 words per group), 01 selects two (4 words), and 10 or 11 selects four (8 words). Routing fields of inactive channels have no effect on the output.
- R5: With decimation setting D, one group is captured every D+1 clock cycles. All active channels are captured at that same instant.
- R6: A configuration write takes effect only at a group capture. Every emitted group is formed entirely under one routing and one channel count.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and the position within the group stay unchanged and `out_valid` stays high.
- R8: If a new group is captured while the previous group still has words outstanding (other than its last word being accepted in that same cycle), the new group is discarded whole and `overrun` rises and stays high until reset. A group of 2N words therefore fits without overrun when D+1 is at least 2N and `out_ready` stays high.
- R9: A synchronous active-low reset clears `out_valid` and `overrun`, returns the position to channel 0 in-phase, and sets the configuration to one channel, all routing fields to converter 0, and decimation setting 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adc_bus | input | 48 | Four 12-bit converter samples, converter k in bits 12k+11..12k |
| cfg_we | input | 1 | Write strobe for the staged configuration |
| cfg_route | input | 16 | Four 4-bit channel fields: in-phase select low pair, quadrature select high pair |
| cfg_nchan | input | 2 | Active channel count code |
| cfg_decim | input | 8 | Decimation setting D, group period D+1 cycles |
| out_data | output | 16 | Signed output word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Host accepts the word this cycle |
| overrun | output | 1 | Sticky flag: a group was discarded |

## Verification
A converter value present at a capture edge appears as the first word of its group on the second rising edge after that capture. The remaining words follow one per accepted cycle, and successive groups begin D+1 cycles apart. A configuration write reaches the datapath at the first capture after the write, and the group captured next is the first one to use it. The bench changes inputs just after a rising edge and reads outputs on the falling edge. It does not predict absolute cycles across a configuration change. Instead it waits out two old periods, then checks the period by timing successive rises of `out_valid`, and checks the content either by aligning the word stream to the expected group pattern or by splitting it into groups at idle gaps.

// File: rtl/rx_route_pkg.sv
// Shared constants and types for the receive router and interleaver.
// Assumes exactly four converters and up to four channels, which the
// 1/2/4 channel modes depend on.
package rx_route_pkg;

    localparam int NUM_ADC = 4;
    localparam int NUM_CH  = 4;
    localparam int SEL_W   = $clog2(NUM_ADC);
    localparam int MODE_W  = 2;
    localparam int MAXW    = 2 * NUM_CH;
    localparam int IDX_W   = $clog2(MAXW);

    // Per-channel routing field: in-phase select in the low bits.
    typedef struct packed {
        logic [SEL_W-1:0] q_sel;
        logic [SEL_W-1:0] i_sel;
    } route_t;

    typedef route_t [NUM_CH-1:0] route_arr_t;

    localparam int ROUTE_W = $bits(route_arr_t);

    // Word count of one group for a channel-count code.
    function automatic logic [IDX_W:0] words_for_mode(input logic [MODE_W-1:0] m);
        case (m)
            2'b00:   return (IDX_W+1)'(2);
            2'b01:   return (IDX_W+1)'(4);
            default: return (IDX_W+1)'(MAXW);
        endcase
    endfunction

endpackage

// File: rtl/rx_cfg_bank.sv
// Staged configuration. Writes land in a shadow copy at once. The
// active copy follows the shadow only on a group capture, so the
// datapath sees new settings only between groups.
// Assumes grp_cap is a single-cycle pulse from the decimation stub.
module rx_cfg_bank
    import rx_route_pkg::*;
#(
    parameter int DEC_W     = 8,
    parameter int RST_DECIM = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  route_arr_t        wr_route,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic [DEC_W-1:0]  wr_decim,
    input  logic              grp_cap,
    output route_arr_t        act_route,
    output logic [MODE_W-1:0] act_mode,
    output logic [DEC_W-1:0]  act_decim
);

    route_arr_t        sh_route;
    logic [MODE_W-1:0] sh_mode;
    logic [DEC_W-1:0]  sh_decim;

    // Shadow copy: follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_route <= '0;
            sh_mode  <= '0;
            sh_decim <= DEC_W'(RST_DECIM);
        end else if (wr_en) begin
            sh_route <= wr_route;
            sh_mode  <= wr_mode;
            sh_decim <= wr_decim;
        end
    end

    // Active copy: moves only at a group boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_route <= '0;
            act_mode  <= '0;
            act_decim <= DEC_W'(RST_DECIM);
        end else if (grp_cap) begin
            act_route <= sh_route;
            act_mode  <= sh_mode;
            act_decim <= sh_decim;
        end
    end

    // R6: settings seen by the datapath never change between captures.
    a_r6_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_cap |=> ($stable(act_route) && $stable(act_mode) && $stable(act_decim)));

endmodule

// File: rtl/rx_xbar.sv
// Converter-to-channel crossbar. Every channel input picks one of the
// converters and widens it with its sign. Purely combinational; one
// converter may drive any number of channel inputs.
module rx_xbar
    import rx_route_pkg::*;
#(
    parameter int ADC_W  = 12,
    parameter int WORD_W = 16
) (
    input  logic [NUM_ADC*ADC_W-1:0]     adc_bus,
    input  route_arr_t                   route,
    output logic [NUM_CH-1:0][WORD_W-1:0] ch_i,
    output logic [NUM_CH-1:0][WORD_W-1:0] ch_q
);

    localparam int EXT_W = WORD_W - ADC_W;

    // Select one converter and widen it with its sign bit.
    function automatic logic [WORD_W-1:0] pick(
        input logic [NUM_ADC*ADC_W-1:0] bus,
        input logic [SEL_W-1:0]         sel
    );
        logic [ADC_W-1:0] s;
        s = bus[sel*ADC_W +: ADC_W];
        return {{EXT_W{s[ADC_W-1]}}, s};
    endfunction

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        // Per-channel in-phase and quadrature selection.
        assign ch_i[c] = pick(adc_bus, route[c].i_sel);
        assign ch_q[c] = pick(adc_bus, route[c].q_sel);
    end

endmodule

// File: rtl/rx_ddc_stub.sv
// Stand-in for the downconverter arithmetic. It counts D+1 cycles per
// output sample and then captures all routed channel samples at once,
// together with the channel-count code they were routed under.
// Assumes the active decimation setting changes only on its own capture.
module rx_ddc_stub
    import rx_route_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DEC_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][WORD_W-1:0] ch_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0] ch_q,
    input  logic [DEC_W-1:0]              act_decim,
    input  logic [MODE_W-1:0]             act_mode,
    output logic                          grp_cap,
    output logic                          res_stb,
    output logic [NUM_CH-1:0][WORD_W-1:0] res_i,
    output logic [NUM_CH-1:0][WORD_W-1:0] res_q,
    output logic [MODE_W-1:0]             res_mode
);

    logic [DEC_W-1:0] cnt;

    assign grp_cap = (cnt == act_decim);

    // Sample-period counter, restarting at each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (grp_cap) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    // Capture one sample per channel and pulse the shared strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_stb  <= 1'b0;
            res_i    <= '0;
            res_q    <= '0;
            res_mode <= '0;
        end else begin
            res_stb <= grp_cap;
            if (grp_cap) begin
                res_i    <= ch_i;
                res_q    <= ch_q;
                res_mode <= act_mode;
            end
        end
    end

    // R5: the period counter never passes the active setting.
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_decim);

    // R5: the captured results hold between strobes.
    a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !res_stb |=> ($stable(res_i) && $stable(res_q)) || res_stb);

endmodule

// File: rtl/rx_word_ser.sv
// Group serializer. On the shared strobe it loads a whole group when it
// is idle or finishing its last word. Otherwise it drops the group and
// sets a sticky overrun flag. It sends channel-ordered in-phase/
// quadrature words under a valid/ready handshake.
// Assumes res_stb is a one-cycle pulse with res_* valid in that cycle.
module rx_word_ser
    import rx_route_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          res_stb,
    input  logic [NUM_CH-1:0][WORD_W-1:0] res_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0] res_q,
    input  logic [MODE_W-1:0]             res_mode,
    output logic [WORD_W-1:0]             out_data,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic                          overrun
);

    logic [NUM_CH-1:0][WORD_W-1:0] grp_i;
    logic [NUM_CH-1:0][WORD_W-1:0] grp_q;
    logic [IDX_W-1:0]              idx;
    logic [IDX_W:0]                nwords;
    logic                          busy;
    logic                          fire;
    logic                          last;
    logic                          take;
    logic [IDX_W-2:0]              ch_sel;

    assign fire   = busy && out_ready;
    assign last   = (idx == IDX_W'(nwords - 1'b1));
    assign take   = res_stb && (!busy || (fire && last));
    assign ch_sel = idx[IDX_W-1:1];

    // Group storage: loaded only when a group is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_i  <= '0;
            grp_q  <= '0;
            nwords <= '0;
        end else if (take) begin
            grp_i  <= res_i;
            grp_q  <= res_q;
            nwords <= words_for_mode(res_mode);
        end
    end

    // Position within the group and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (fire) begin
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Sticky overrun: a strobe arrived that could not be taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overrun <= 1'b0;
        else if (res_stb && !take)  overrun <= 1'b1;
    end

    // Word select: channel from the upper index bits, I or Q from bit 0.
    always_comb begin
        out_data = idx[0] ? grp_q[ch_sel] : grp_i[ch_sel];
    end

    assign out_valid = busy;

    // R7: a stalled word and its position stay put.
    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(idx)));

    // R3: position stays inside the group.
    a_r3_idx_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, idx} < nwords));

    // R3: an accepted non-final word advances the position by one.
    a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last && !res_stb) |=> (idx == $past(idx) + 1'b1));

    // R8: a group in flight is never overwritten by a dropped one.
    a_r8_group_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(fire && last)) |=> ($stable(grp_i) && $stable(grp_q)));

    // R8: overrun stays set until reset.
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R9: reset leaves the serializer idle and the flag clear.
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !overrun && idx == '0));

endmodule

// File: rtl/rx_route_ilv.sv
// Top level: staged configuration, converter crossbar, decimating
// stub and word serializer, wired in that order.
// Assumes ADC_W < WORD_W and four converters and channels.
module rx_route_ilv
    import rx_route_pkg::*;
#(
    parameter int ADC_W     = 12,
    parameter int WORD_W    = 16,
    parameter int DEC_W     = 8,
    parameter int RST_DECIM = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ADC*ADC_W-1:0] adc_bus,
    input  logic                     cfg_we,
    input  logic [ROUTE_W-1:0]       cfg_route,
    input  logic [MODE_W-1:0]        cfg_nchan,
    input  logic [DEC_W-1:0]         cfg_decim,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     overrun
);

    route_arr_t                    wr_route;
    route_arr_t                    act_route;
    logic [MODE_W-1:0]             act_mode;
    logic [DEC_W-1:0]              act_decim;
    logic                          grp_cap;
    logic [NUM_CH-1:0][WORD_W-1:0] ch_i;
    logic [NUM_CH-1:0][WORD_W-1:0] ch_q;
    logic                          res_stb;
    logic [NUM_CH-1:0][WORD_W-1:0] res_i;
    logic [NUM_CH-1:0][WORD_W-1:0] res_q;
    logic [MODE_W-1:0]             res_mode;

    assign wr_route = route_arr_t'(cfg_route);

    rx_cfg_bank #(.DEC_W(DEC_W), .RST_DECIM(RST_DECIM)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_route  (wr_route),
        .wr_mode   (cfg_nchan),
        .wr_decim  (cfg_decim),
        .grp_cap   (grp_cap),
        .act_route (act_route),
        .act_mode  (act_mode),
        .act_decim (act_decim)
    );

    rx_xbar #(.ADC_W(ADC_W), .WORD_W(WORD_W)) u_xbar (
        .adc_bus (adc_bus),
        .route   (act_route),
        .ch_i    (ch_i),
        .ch_q    (ch_q)
    );

    rx_ddc_stub #(.WORD_W(WORD_W), .DEC_W(DEC_W)) u_ddc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_i      (ch_i),
        .ch_q      (ch_q),
        .act_decim (act_decim),
        .act_mode  (act_mode),
        .grp_cap   (grp_cap),
        .res_stb   (res_stb),
        .res_i     (res_i),
        .res_q     (res_q),
        .res_mode  (res_mode)
    );

    rx_word_ser #(.WORD_W(WORD_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_stb   (res_stb),
        .res_i     (res_i),
        .res_q     (res_q),
        .res_mode  (res_mode),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .overrun   (overrun)
    );

    // R1: every word presented carries a proper sign extension.
    a_r1_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data[WORD_W-1:ADC_W-1] == '0) ||
                       (out_data[WORD_W-1:ADC_W-1] == '1)));

endmodule

// File: tb/rx_route_ilv_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, period, backpressure, boundary changes and overrun.
module rx_route_ilv_bench;

    typedef struct packed {
        logic [15:0] rt;
        logic [1:0]  md;
        logic [7:0]  dc;
        logic [47:0] adc;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{16'h93E4, 2'd2, 8'd20, 48'hF00_7FF_8A5_123},
        '{16'h55B1, 2'd1, 8'd12, 48'h001_800_3C3_FFF},
        '{16'hA5AF, 2'd0, 8'd9,  48'h5A5_A5A_000_C01},
        '{16'h2222, 2'd3, 8'd30, 48'h7FE_801_456_ABC},
        '{16'h1B4E, 2'd2, 8'd8,  48'h0F0_F0F_7F0_80F}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] adc_bus;
    logic        cfg_we;
    logic [15:0] cfg_route;
    logic [1:0]  cfg_nchan;
    logic [7:0]  cfg_decim;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready;
    logic        overrun;

    int  nchecks = 0;
    int  nfail   = 0;
    int  cyc     = 0;
    bit  done    = 1'b0;
    bit  prev_idle = 1'b1;
    logic [15:0] wq[$];
    bit          sq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_route_ilv u_rx_route_ilv (
        .clk(clk), .rst_n(rst_n), .adc_bus(adc_bus), .cfg_we(cfg_we),
        .cfg_route(cfg_route), .cfg_nchan(cfg_nchan), .cfg_decim(cfg_decim),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .overrun(overrun)
    );

    // Word monitor: records accepted words and whether each began after idle.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            wq.push_back(out_data);
            sq.push_back(prev_idle);
        end
        prev_idle = !out_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_q();
        step();
        wq.delete();
        sq.delete();
    endtask

    task automatic write_cfg(input logic [15:0] rt, input logic [1:0] md, input logic [7:0] dc);
        step();
        cfg_route = rt; cfg_nchan = md; cfg_decim = dc; cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    function automatic int nw_of(input logic [1:0] md);
        return (md == 2'b00) ? 2 : (md == 2'b01) ? 4 : 8;
    endfunction

    // Expected word k of a group, from the R1/R2/R3 field definitions.
    function automatic logic [15:0] exp_word(input logic [15:0] rt, input logic [47:0] adc, input int k);
        int ch;
        logic [1:0] sel;
        logic [11:0] s;
        ch  = k / 2;
        sel = (k % 2 == 1) ? rt[4*ch+2 +: 2] : rt[4*ch +: 2];
        s   = adc[sel*12 +: 12];
        return {{4{s[11]}}, s};
    endfunction

    function automatic bit grp_match(input logic [15:0] g[$], input logic [15:0] rt,
                                     input logic [47:0] adc, input int nw);
        if (g.size() != nw) return 1'b0;
        for (int j = 0; j < nw; j++)
            if (g[j] != exp_word(rt, adc, j)) return 1'b0;
        return 1'b1;
    endfunction

    // Stream check: the whole queue follows the group pattern at one alignment.
    task automatic align_check(input logic [15:0] rt, input logic [47:0] adc, input int nw, input string tag);
        bit found = 1'b0;
        chk(wq.size() >= 2*nw, {tag, " word count"}, wq.size(), 2*nw);
        for (int k = 0; k < nw; k++) begin
            bit ok = 1'b1;
            for (int j = 0; j < wq.size(); j++)
                if (wq[j] != exp_word(rt, adc, (j + k) % nw)) ok = 1'b0;
            if (ok) found = 1'b1;
        end
        chk(found, {tag, " word order"}, (wq.size() > 0) ? wq[0] : 16'hxxxx, exp_word(rt, adc, 0));
    endtask

    // Group check: split at idle gaps; each whole group matches A or B.
    task automatic group_check(input logic [15:0] rta, input logic [15:0] rtb, input logic [47:0] adc,
                               input int nw, input string tag);
        logic [15:0] g[$];
        bit started = 1'b0;
        int ngrp = 0;
        bit last_b = 1'b0;
        for (int i = 0; i <= wq.size(); i++) begin
            if (i == wq.size() || sq[i]) begin
                if (started && (i < wq.size() || g.size() == nw)) begin
                    bit ma = grp_match(g, rta, adc, nw);
                    bit mb = grp_match(g, rtb, adc, nw);
                    chk(ma || mb, {tag, " whole group"}, g.size(), nw);
                    last_b = mb;
                    ngrp++;
                end
                g.delete();
                started = (i < wq.size());
            end
            if (started && i < wq.size()) g.push_back(wq[i]);
        end
        chk(ngrp >= 2, {tag, " groups seen"}, ngrp, 2);
        chk(last_b, {tag, " final routing"}, last_b, 1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; out_ready = 1'b1; cfg_we = 1'b0;
        cfg_route = '0; cfg_nchan = '0; cfg_decim = 8'd15;
        adc_bus = 48'h123_456_789_9C4;
        repeat (3) @(negedge clk);
        // R9: outputs idle in reset
        chk(!out_valid && !overrun, "R9 reset outputs", {out_valid, overrun}, 0);
        step();
        rst_n = 1'b1;
        clear_q();
        repeat (90) step();
        // R9 / R4: defaults are one channel from converter 0, 2 words per group
        group_check(16'h0000, 16'h0000, adc_bus, 2, "R9 R4 defaults");
        chk(wq.size() > 0 && wq[0] == 16'hF9C4, "R1 sign extension of 9C4",
            (wq.size() > 0) ? wq[0] : 16'h0, 16'hF9C4);

        // Table walk: R1 R2 R3 R4 across routes, modes and periods
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(VEC[v].rt, VEC[v].md, VEC[v].dc);
            adc_bus = VEC[v].adc;
            repeat (192) step();
            clear_q();
            repeat (6 * (VEC[v].dc + 1) + 10) step();
            align_check(VEC[v].rt, VEC[v].adc, nw_of(VEC[v].md), $sformatf("R2 R3 R4 vec%0d", v));
        end

        // R5: group period is D+1 cycles
        write_cfg(VEC[0].rt, VEC[0].md, 8'd20);
        adc_bus = VEC[0].adc;
        repeat (192) step();
        begin
            int t0 = -1;
            int t1 = -1;
            bit pv = 1'b1;
            while (t1 < 0) begin
                @(negedge clk);
                if (out_valid && !pv) begin
                    if (t0 < 0) t0 = cyc; else t1 = cyc;
                end
                pv = out_valid;
            end
            chk(t1 - t0 == 21, "R5 group period", t1 - t0, 21);
        end

        // R6: routing changes mid-stream; every group is all-old or all-new
        write_cfg(VEC[0].rt, 2'd2, 8'd40);
        repeat (120) step();
        clear_q();
        repeat (57) step();
        write_cfg(16'h1B4E, 2'd2, 8'd40);
        repeat (33) step();
        write_cfg(VEC[0].rt, 2'd2, 8'd40);
        repeat (71) step();
        write_cfg(16'h1B4E, 2'd2, 8'd40);
        repeat (200) step();
        group_check(VEC[0].rt, 16'h1B4E, VEC[0].adc, 8, "R6 boundary");

        // R7: stall holds the word, then a toggling ready keeps order
        write_cfg(VEC[0].rt, 2'd2, 8'd40);
        repeat (120) step();
        out_ready = 1'b0;
        begin
            logic [15:0] held;
            @(negedge clk);
            while (!out_valid) @(negedge clk);
            held = out_data;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                chk(out_valid && out_data == held, "R7 stalled word held", out_data, held);
            end
        end
        clear_q();
        for (int i = 0; i < 240; i++) begin
            step();
            out_ready = (i % 3) != 0;
        end
        step();
        out_ready = 1'b1;
        align_check(VEC[0].rt, VEC[0].adc, 8, "R7 order under backpressure");

        // R8 boundary: D=7 with 8 words fits exactly
        chk(!overrun, "R8 no overrun so far", overrun, 0);
        write_cfg(VEC[4].rt, 2'd2, 8'd7);
        adc_bus = VEC[4].adc;
        repeat (100) step();
        clear_q();
        repeat (100) step();
        chk(!overrun, "R8 D=7 four channels no overrun", overrun, 0);
        align_check(VEC[4].rt, VEC[4].adc, 8, "R8 back-to-back groups");

        // R8: D=6 cannot fit 8 words; groups dropped whole, flag sticky
        write_cfg(VEC[4].rt, 2'd2, 8'd6);
        repeat (60) step();
        @(negedge clk);
        chk(overrun, "R8 overrun raised", overrun, 1);
        clear_q();
        repeat (150) step();
        group_check(VEC[4].rt, VEC[4].rt, VEC[4].adc, 8, "R8 dropped whole");
        write_cfg(VEC[4].rt, 2'd2, 8'd40);
        repeat (100) step();
        @(negedge clk);
        chk(overrun, "R8 overrun sticky", overrun, 1);

        // R9: reset mid-group clears state and configuration
        out_ready = 1'b0;
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        step();
        rst_n = 1'b0;
        step();
        step();
        @(negedge clk);
        chk(!out_valid && !overrun, "R9 reset mid-group", {out_valid, overrun}, 0);
        step();
        rst_n = 1'b1;
        out_ready = 1'b1;
        adc_bus = 48'h7FF_000_800_0A5;
        clear_q();
        repeat (80) step();
        group_check(16'h0000, 16'h0000, adc_bus, 2, "R9 restart at defaults");
        chk(wq.size() > 0 && wq[0] == 16'h00A5, "R9 first word after reset",
            (wq.size() > 0) ? wq[0] : 16'h0, 16'h00A5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

endmodule